// File: doc/BRIEF.md
# Register-List Memory Micro-op Sequencer

This block turns one decoded load-multiple or store-multiple request into a stream of simple micro-ops. A request names a base register and carries a bit mask of registers to transfer, plus five flags: pre/post indexing, counting direction, user-bank access, base writeback and load versus store. It is accepted through a valid/ready handshake. The block then walks the mask and presents one micro-op per cycle on a valid/ready output until the last one is taken.

The stream always opens by copying the base register into a scratch register (index 16) through an add of zero. Every transfer then addresses memory relative to that scratch copy, using an unsigned byte offset and a direction bit. The offset starts out biased for the addressing mode and moves by four bytes per transfer. A writeback micro-op adjusts the base by four bytes per listed register. It is placed right after the copy for loads and after the final transfer for stores. The user flag, read together with mask bit 15, selects between transfers to the user register bank and the exception-return form of the load of register 15.

Top module: `lsm_uop_seq`

## Requirements
- R1: `req_ready` is high exactly when no sequence is in progress, and a request is taken on a cycle with `req_valid` and `req_ready` both high. A micro-op is consumed only on a cycle with `uop_valid` and `uop_ready` both high. While it waits, its opcode, destination and offset hold steady.
- R2: A request produces popcount(list) + 1 micro-ops, plus one more when writeback is requested.
- R3: The first micro-op has opcode 0 (move, an add of zero). Its destination is 16 (the scratch register), its source is the base and its offset is 0. Every transfer carries source 16.
- R4: The first transfer's offset is 0 when counting up and popcount×4−4 when counting down, with 4 added in either case when the index flag is clear.
- R5: With writeback, the writeback micro-op follows the move directly for a load and follows the last transfer for a store.
- R6: The writeback micro-op has opcode 1 (add-immediate) when counting up and opcode 2 (subtract-immediate) when counting down. Its destination and source are both the base, and its offset is popcount×4.
- R7: Transfers visit the set mask bits from lowest to highest index, with the register index as destination. Each offset differs from the previous one by 4, upward or downward as the up flag says. `uop_up` carries the request's up flag on every micro-op.
- R8: With the user flag set and mask bit 15 clear, every transfer has `uop_user_bank` high. In all other cases, and on every non-transfer micro-op, it is low.
- R9: Loads use opcode 3 and stores use opcode 5. With the user flag and mask bit 15 both set, the load of register 15 uses opcode 4 (exception-return load), and a store of register 15 keeps opcode 5.
- R10: Only the final micro-op has `uop_last` high. Every earlier one has `uop_dcommit` high and the final one has it low. After the final micro-op is taken, `uop_valid` falls.
- R11: An empty mask yields the move alone, or the move followed by the writeback micro-op when writeback is requested, and the final one carries `uop_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_base | input | 4 | Base register index |
| req_list | input | 16 | Register mask, bit n for register n |
| req_index | input | 1 | Pre-index (1) or post-index (0) |
| req_up | input | 1 | Count upward (1) or downward (0) |
| req_user | input | 1 | User-bank / exception-return qualifier |
| req_wb | input | 1 | Write the adjusted base back |
| req_load | input | 1 | Load (1) or store (0) |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 3 | Opcode: 0 move, 1 add-imm, 2 sub-imm, 3 load, 4 exception-return load, 5 store |
| uop_dst | output | 5 | Destination register, 16 is the scratch register |
| uop_src | output | 5 | Source or address register |
| uop_user_bank | output | 1 | Transfer targets the user register bank |
| uop_offset | output | 7 | Unsigned byte offset or immediate |
| uop_up | output | 1 | Offset direction |
| uop_last | output | 1 | Final micro-op of the sequence |
| uop_dcommit | output | 1 | Commit held back until the sequence ends |

## Verification
The assertions read the request fields only on the accepting cycle and put no limit on them. They accept any pattern on `uop_ready`, including long stalls. They assume only that reset is applied before the first request. The stimulus holds every request field steady for the whole cycle in which `req_valid` is high and drops `req_valid` right after acceptance. Consumer stalls come from a fixed period-three pattern, so the hold rule and the offset-step rule are both exercised across stalled and unstalled cycles.

// File: rtl/lsm_uop_pkg.sv
package lsm_uop_pkg;

  typedef enum logic [2:0] {
    OP_MOV   = 3'd0,
    OP_ADDI  = 3'd1,
    OP_SUBI  = 3'd2,
    OP_LD    = 3'd3,
    OP_LDRET = 3'd4,
    OP_ST    = 3'd5
  } uop_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_COPY = 3'd1,
    ST_WBE  = 3'd2,
    ST_XFER = 3'd3,
    ST_WBL  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_uop_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int REG_W  = $clog2(LIST_W),
  parameter int OFS_W  = $clog2(LIST_W * 4 + 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [REG_W-1:0]   req_base,
  input  logic [LIST_W-1:0]  req_list,
  input  logic               req_index,
  input  logic               req_up,
  input  logic               req_user,
  input  logic               req_wb,
  input  logic               req_load,
  output logic               uop_valid,
  input  logic               uop_ready,
  output logic [2:0]         uop_op,
  output logic [REG_W:0]     uop_dst,
  output logic [REG_W:0]     uop_src,
  output logic               uop_user_bank,
  output logic [OFS_W-1:0]   uop_offset,
  output logic               uop_up,
  output logic               uop_last,
  output logic               uop_dcommit
);
  localparam int CNT_W = $clog2(LIST_W + 1);
  localparam logic [REG_W:0]   TEMP_IDX = (REG_W + 1)'(LIST_W);
  localparam logic [OFS_W-1:0] STEP     = OFS_W'(4);

  seq_state_e         state_q, state_d, after;
  logic [LIST_W-1:0]  list_q, list_d, rest;
  logic [REG_W-1:0]   base_q, low_idx;
  logic [CNT_W-1:0]   cnt_q, req_cnt;
  logic [OFS_W-1:0]   ofs_q, ofs_d, start_ofs, req_span, span_q;
  logic               up_q, user_q, wb_q, ld_q, ret_q;
  logic               accept, fire, is_ret15;

  lsm_popcnt #(.W(LIST_W), .CW(CNT_W)) u_pop (.vec(req_list), .cnt(req_cnt));
  lsm_lowbit #(.W(LIST_W), .IW(REG_W)) u_low (.vec(list_q), .idx(low_idx));

  assign req_ready = (state_q == ST_IDLE);
  assign uop_valid = (state_q != ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign fire      = uop_valid & uop_ready;
  assign rest      = list_q & ~(LIST_W'(1) << low_idx);
  assign req_span  = OFS_W'({req_cnt, 2'b00});
  assign span_q    = OFS_W'({cnt_q, 2'b00});

  // Addressing-mode bias of the first transfer offset
  always_comb begin
    start_ofs = req_up ? '0 : (req_span - STEP);
    if (!req_index) start_ofs = start_ofs + STEP;
  end

  // Successor of the current micro-op
  always_comb begin
    after = ST_IDLE;
    case (state_q)
      ST_COPY: begin
        if (ld_q && wb_q)  after = ST_WBE;
        else if (|list_q)  after = ST_XFER;
        else if (wb_q)     after = ST_WBL;
      end
      ST_WBE:  after = (|list_q) ? ST_XFER : ST_IDLE;
      ST_XFER: begin
        if (|rest)             after = ST_XFER;
        else if (!ld_q && wb_q) after = ST_WBL;
      end
      default: after = ST_IDLE;
    endcase
  end

  // Next-state process
  always_comb begin
    state_d = state_q;
    list_d  = list_q;
    ofs_d   = ofs_q;
    if (accept) begin
      state_d = ST_COPY;
      list_d  = req_list;
      ofs_d   = start_ofs;
    end else if (fire) begin
      state_d = after;
      if (state_q == ST_XFER) begin
        list_d = rest;
        ofs_d  = up_q ? (ofs_q + STEP) : (ofs_q - STEP);
      end
    end
  end

  // Sequence state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      list_q  <= '0;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      list_q  <= list_d;
      ofs_q   <= ofs_d;
    end
  end

  // Request fields, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      up_q   <= 1'b0;
      user_q <= 1'b0;
      wb_q   <= 1'b0;
      ld_q   <= 1'b0;
      ret_q  <= 1'b0;
    end else if (accept) begin
      base_q <= req_base;
      cnt_q  <= req_cnt;
      up_q   <= req_up;
      user_q <= req_user;
      wb_q   <= req_wb;
      ld_q   <= req_load;
      ret_q  <= req_user & req_list[LIST_W-1];
    end
  end

  assign is_ret15 = ret_q && (low_idx == REG_W'(LIST_W - 1));

  // Micro-op formatting
  always_comb begin
    uop_op        = OP_MOV;
    uop_dst       = TEMP_IDX;
    uop_src       = {1'b0, base_q};
    uop_offset    = '0;
    uop_user_bank = 1'b0;
    case (state_q)
      ST_WBE, ST_WBL: begin
        uop_op     = up_q ? OP_ADDI : OP_SUBI;
        uop_dst    = {1'b0, base_q};
        uop_offset = span_q;
      end
      ST_XFER: begin
        if (ld_q) uop_op = is_ret15 ? OP_LDRET : OP_LD;
        else      uop_op = OP_ST;
        uop_dst       = {1'b0, low_idx};
        uop_src       = TEMP_IDX;
        uop_offset    = ofs_q;
        uop_user_bank = user_q & ~ret_q;
      end
      default: ;
    endcase
  end

  assign uop_up      = up_q;
  assign uop_last    = uop_valid && (after == ST_IDLE);
  assign uop_dcommit = uop_valid && (after != ST_IDLE);

endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk
  import lsm_uop_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int REG_W  = $clog2(LIST_W),
  parameter int OFS_W  = $clog2(LIST_W * 4 + 8)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [2:0]       uop_op,
  input logic [REG_W:0]   uop_dst,
  input logic [REG_W:0]   uop_src,
  input logic             uop_user_bank,
  input logic [OFS_W-1:0] uop_offset,
  input logic             uop_up,
  input logic             uop_last
);
  logic xfer;
  assign xfer = (uop_op == OP_LD) || (uop_op == OP_LDRET) || (uop_op == OP_ST);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !req_ready);  // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_op) && $stable(uop_dst)
      && $stable(uop_offset));  // R1

  AST_ACCEPT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> uop_valid && uop_op == OP_MOV
      && uop_dst == (REG_W + 1)'(LIST_W) && uop_offset == '0);  // R3

  AST_XFER_SRC_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && xfer |-> uop_src == (REG_W + 1)'(LIST_W));  // R3

  AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && xfer && $past(uop_valid && uop_ready && xfer) |->
      uop_offset == (uop_up ? $past(uop_offset) + OFS_W'(4)
                            : $past(uop_offset) - OFS_W'(4)));  // R7

  AST_BANK_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_user_bank |-> xfer && uop_op != OP_LDRET);  // R8

  AST_RET_REG15: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_op == OP_LDRET |-> uop_dst == (REG_W + 1)'(LIST_W - 1));  // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && uop_last |=> !uop_valid);  // R10

  AST_NOT_LAST_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && !uop_last |=> uop_valid);  // R10

endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.LIST_W(LIST_W), .REG_W(REG_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op), .uop_dst(uop_dst),
  .uop_src(uop_src), .uop_user_bank(uop_user_bank), .uop_offset(uop_offset),
  .uop_up(uop_up), .uop_last(uop_last)
);

// File: tb/lsm_uop_seq_bench.sv
module lsm_uop_seq_bench;
  localparam int LW = 16;
  localparam int OW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [3:0]    req_base;
  logic [LW-1:0] req_list;
  logic          req_index, req_up, req_user, req_wb, req_load;
  logic          uop_valid, uop_ready;
  logic [2:0]    uop_op;
  logic [4:0]    uop_dst, uop_src;
  logic          uop_user_bank;
  logic [OW-1:0] uop_offset;
  logic          uop_up, uop_last, uop_dcommit;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  int    e_op [20];
  int    e_dst[20];
  int    e_src[20];
  int    e_ofs[20];
  int    e_bnk[20];
  string e_tag[20];
  int    e_n;

  always #2 clk = ~clk;

  lsm_uop_seq u_lsm_uop_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_list(req_list), .req_index(req_index), .req_up(req_up),
    .req_user(req_user), .req_wb(req_wb), .req_load(req_load),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op), .uop_dst(uop_dst),
    .uop_src(uop_src), .uop_user_bank(uop_user_bank), .uop_offset(uop_offset),
    .uop_up(uop_up), .uop_last(uop_last), .uop_dcommit(uop_dcommit)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int op, input int dst, input int src, input int ofs,
                      input int bnk, input string tag);
    e_op[e_n]  = op;
    e_dst[e_n] = dst;
    e_src[e_n] = src;
    e_ofs[e_n] = ofs;
    e_bnk[e_n] = bnk;
    e_tag[e_n] = tag;
    e_n = e_n + 1;
  endtask

  task automatic model(input int base, input logic [LW-1:0] list, input bit index,
                       input bit up, input bit user, input bit wb, input bit load);
    int pc;
    int ofs;
    int op;
    pc  = $countones(list);
    e_n = 0;
    push(0, 16, base, 0, 0, "R3");
    if (load && wb) push(up ? 1 : 2, base, base, pc * 4, 0, "R5 R6");
    ofs = up ? 0 : pc * 4 - 4;
    if (!index) ofs = ofs + 4;
    for (int r = 0; r < LW; r++) begin
      if (list[r]) begin
        if (load) op = (user && list[15] && r == 15) ? 4 : 3;
        else      op = 5;
        push(op, r, 16, ofs, (user && !list[15]) ? 1 : 0, "R4 R7 R8 R9");
        ofs = up ? ofs + 4 : ofs - 4;
      end
    end
    if (!load && wb) push(up ? 1 : 2, base, base, pc * 4, 0, "R5 R6");
  endtask

  task automatic run(input string name, input int base, input logic [LW-1:0] list,
                     input bit index, input bit up, input bit user, input bit wb,
                     input bit load, input bit stall);
    int k;
    int guard;
    bit done;
    bit held;
    int h_op, h_dst, h_ofs;
    string t;
    model(base, list, index, up, user, wb, load);
    @(negedge clk);
    chk(req_ready == 1'b1, {name, " R1 ready when idle"}, req_ready, 1);
    req_valid = 1'b1; req_base = 4'(base); req_list = list; req_index = index;
    req_up = up; req_user = user; req_wb = wb; req_load = load;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {name, " R1 busy not ready"}, req_ready, 0);
    k = 0; guard = 0; done = 0; held = 0;
    h_op = 0; h_dst = 0; h_ofs = 0;
    while (!done && guard < 200) begin
      if (held) begin
        chk(uop_valid && int'(uop_op) == h_op && int'(uop_dst) == h_dst
            && int'(uop_offset) == h_ofs, {name, " R1 stalled uop held"},
            int'(uop_offset), h_ofs);
        held = 0;
      end
      uop_ready = (!stall) || ((guard % 3) != 1);
      if (uop_valid && uop_ready) begin
        if (k >= e_n) begin
          chk(0, {name, " R2 extra uop"}, k + 1, e_n);
          done = 1;
        end else begin
          t = {name, " ", e_tag[k]};
          chk(int'(uop_op) == e_op[k], {t, " op"}, int'(uop_op), e_op[k]);
          chk(int'(uop_dst) == e_dst[k], {t, " dst"}, int'(uop_dst), e_dst[k]);
          chk(int'(uop_src) == e_src[k], {t, " src"}, int'(uop_src), e_src[k]);
          chk(int'(uop_offset) == e_ofs[k], {t, " offset"}, int'(uop_offset), e_ofs[k]);
          chk(int'(uop_user_bank) == e_bnk[k], {t, " bank"}, int'(uop_user_bank), e_bnk[k]);
          chk(uop_up == up, {t, " R7 direction"}, int'(uop_up), int'(up));
          chk(uop_last == (k == e_n - 1), {name, " R10 last"}, int'(uop_last),
              int'(k == e_n - 1));
          chk(uop_dcommit == (k != e_n - 1), {name, " R10 dcommit"}, int'(uop_dcommit),
              int'(k != e_n - 1));
          if (uop_last) done = 1;
          k = k + 1;
        end
      end else if (uop_valid) begin
        held  = 1;
        h_op  = int'(uop_op);
        h_dst = int'(uop_dst);
        h_ofs = int'(uop_offset);
      end
      @(posedge clk);
      @(negedge clk);
      guard = guard + 1;
    end
    uop_ready = 1'b0;
    chk(k == e_n, {name, " R2 uop count"}, k, e_n);
    chk(!uop_valid, {name, " R10 valid drops after last"}, int'(uop_valid), 0);
    chk(req_ready, {name, " R1 ready again"}, int'(req_ready), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; uop_ready = 1'b0;
    req_base = '0; req_list = '0; req_index = 0; req_up = 0;
    req_user = 0; req_wb = 0; req_load = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!uop_valid, "R1 reset uop_valid low", int'(uop_valid), 0);
    chk(req_ready, "R1 reset req_ready high", int'(req_ready), 1);
  endtask

  task automatic t_load_up_wb();
    run("load up pre wb", 13, 16'h00F1, 1, 1, 0, 1, 1, 0);
  endtask

  task automatic t_store_down_wb();
    run("store down pre wb stalled", 2, 16'h8421, 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_store_up_post();
    run("store up post", 7, 16'h0006, 0, 1, 0, 0, 0, 1);
  endtask

  task automatic t_load_down_post();
    run("load down post", 1, 16'h0C00, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_user_variants();
    run("R8 user load bank", 3, 16'h0103, 1, 1, 1, 0, 1, 1);
    run("R9 user load ret", 4, 16'h8003, 1, 1, 1, 1, 1, 0);
    run("R9 user store r15", 5, 16'h8010, 0, 0, 1, 0, 0, 1);
    run("R8 user store bank", 6, 16'h4001, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_empty();
    run("R11 empty load wb", 9, 16'h0000, 1, 1, 0, 1, 1, 0);
    run("R11 empty store wb", 10, 16'h0000, 0, 0, 0, 1, 0, 1);
    run("R11 empty no wb", 11, 16'h0000, 1, 0, 0, 0, 1, 0);
  endtask

  task automatic t_full();
    run("full load down pre wb", 0, 16'hFFFF, 1, 0, 0, 1, 1, 1);
    run("full store up post", 15, 16'hFFFF, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_load_up_wb();
    t_store_down_wb();
    t_store_up_post();
    t_load_down_post();
    t_user_variants();
    t_empty();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule